// File: doc/BRIEF.md
# Next-Hop Adjacency Table with Activity Tracking

This block stores the next-hop records a routing datapath consults after route selection. Each record carries a valid flag, a hardware-maintained activity flag, an egress interface number, a trap action, a trap identifier and a 48-bit destination MAC.

Software reaches the table through a management port. It presents a command code, a 24-bit index split into a 16-bit low part and an 8-bit high part, and write data. After the command is accepted, one response returns the status and an entry image. The forwarding pipeline reads the table through a separate lookup port. A lookup that lands on a valid entry marks that entry active, so software can age out next hops that are no longer used.

Invalidating an entry starts a per-entry quarantine. Management commands that reach the entry before the quarantine ends are refused with a retry status.

Top module: `nh_adj_table`

## Requirements
- R1: After reset every entry is invalid with its activity flag clear, `cmd_ready` is 1, and `rsp_valid` and `lk_rsp_valid` are 0.
- R2: Command code 0 (read) returns status 0 and the stored entry, including the valid and activity flags, and changes no state.
- R3: Command code 2 (read and clear) returns status 0 and the entry as it was before the command, then clears the entry's activity flag.
- R4: Command code 1 (write) stores the valid flag, egress interface, trap action, trap identifier and MAC. The activity flag becomes equal to the written valid flag. The response carries the entry as it is after the write.
- R5: Command code 3 (conditional write) behaves like R4 only when the entry's activity flag is 0. Otherwise the entry is left unchanged. The status is 0 in both cases, and the response carries the entry as it is after the command.
- R6: A successful write with valid 0 starts a quarantine of `QUAR_CYCLES` clock edges on that entry. A command whose execute edge falls within that window returns status 1 (retry), zero data, and has no effect.
- R7: An index `{hi,lo}` equal to or greater than `DEPTH` returns status 2 with zero data and no effect.
- R8: A command code above 3 returns status 3 with zero data and no effect. A write or conditional write with trap action above 4 (0 no-op, 1 trap, 2 mirror to CPU, 3 mirror, 4 discard on errors) or trap identifier above 1 also returns status 3 with zero data and no effect. Status is chosen in this order: bad code, then range, then quarantine, then field check.
- R9: `lk_rsp_valid` rises one cycle after `lk_req`. If the index is in range and the entry is valid, `lk_hit` is 1 and the entry's fields are returned. Otherwise `lk_hit` is 0 and all fields are 0. A hit sets the entry's activity flag.
- R10: When a lookup hit and a read-and-clear execute on the same entry in the same cycle, the read-and-clear reports the prior flag and the flag ends at 1.
- R11: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 in the following cycle, and `rsp_valid` is 1 for exactly one cycle, two cycles after the acceptance cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Management command present |
| cmd_ready | output | 1 | Management command can be accepted |
| cmd_op | input | 4 | Command code (0 read, 1 write, 2 read and clear, 3 conditional write) |
| cmd_idx_lo | input | 16 | Index bits 15:0 |
| cmd_idx_hi | input | 8 | Index bits 23:16 |
| cmd_wr_valid | input | 1 | Valid flag to write |
| cmd_wr_egress | input | 16 | Egress interface to write |
| cmd_wr_trap_act | input | 4 | Trap action to write |
| cmd_wr_trap_id | input | 8 | Trap identifier to write |
| cmd_wr_mac | input | 48 | Destination MAC to write |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | 0 ok, 1 retry, 2 out of range, 3 bad request |
| rsp_entry_valid | output | 1 | Entry valid flag |
| rsp_entry_active | output | 1 | Entry activity flag |
| rsp_egress | output | 16 | Entry egress interface |
| rsp_trap_act | output | 4 | Entry trap action |
| rsp_trap_id | output | 8 | Entry trap identifier |
| rsp_mac | output | 48 | Entry destination MAC |
| lk_req | input | 1 | Lookup request |
| lk_idx | input | 24 | Lookup index |
| lk_rsp_valid | output | 1 | Lookup result present |
| lk_hit | output | 1 | Looked-up entry is valid |
| lk_egress | output | 16 | Egress interface of the hit |
| lk_trap_act | output | 4 | Trap action of the hit |
| lk_trap_id | output | 8 | Trap identifier of the hit |
| lk_mac | output | 48 | Destination MAC of the hit |

## Verification
The properties assume that `cmd_valid`, `cmd_op`, both index parts and `lk_req` are never unknown once reset is released. They also assume that reset is held low across at least one rising clock edge, because the latency checks look two edges into the past. The stimulus drives every input to a defined value from time zero and changes inputs only shortly after a falling edge, so every rising edge samples stable values. Retry windows, collisions and out-of-range cases come up often because the random phase confines indexes to a few entries around the top of the table and mixes invalidating writes among the reads.

// File: rtl/nh_adj_pkg.sv
package nh_adj_pkg;

    localparam int IDX_W     = 24;
    localparam int IDX_LO_W  = 16;
    localparam int IDX_HI_W  = 8;
    localparam int EGR_W     = 16;
    localparam int MAC_W     = 48;
    localparam int OP_W      = 4;
    localparam int TACT_W    = 4;
    localparam int TACT_ST_W = 3;
    localparam int TID_W     = 8;
    localparam int ST_W      = 2;

    localparam logic [OP_W-1:0] OP_READ       = 4'd0;
    localparam logic [OP_W-1:0] OP_WRITE      = 4'd1;
    localparam logic [OP_W-1:0] OP_READ_CLR   = 4'd2;
    localparam logic [OP_W-1:0] OP_WRITE_IDLE = 4'd3;

    localparam logic [ST_W-1:0] ST_OK     = 2'd0;
    localparam logic [ST_W-1:0] ST_RETRY  = 2'd1;
    localparam logic [ST_W-1:0] ST_RANGE  = 2'd2;
    localparam logic [ST_W-1:0] ST_BADREQ = 2'd3;

    localparam logic [TACT_W-1:0] TACT_MAX = 4'd4;
    localparam logic [TID_W-1:0]  TID_MAX  = 8'd1;

    typedef struct packed {
        logic                 vld;
        logic                 act;
        logic [EGR_W-1:0]     egress;
        logic [TACT_ST_W-1:0] tact;
        logic                 tid;
        logic [MAC_W-1:0]     mac;
    } nh_entry_t;

endpackage

// File: rtl/nh_cmd_decode.sv
module nh_cmd_decode
    import nh_adj_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic [OP_W-1:0]   op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TACT_W-1:0] wr_tact,
    input  logic [TID_W-1:0]  wr_tid,
    input  logic              ent_busy,
    input  logic              ent_act,
    output logic [ST_W-1:0]   status,
    output logic              is_read,
    output logic              do_write,
    output logic              do_clear
);
    localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);

    logic op_is_wr;
    logic fields_ok;

    assign op_is_wr  = (op == OP_WRITE) || (op == OP_WRITE_IDLE);
    assign fields_ok = (wr_tact <= TACT_MAX) && (wr_tid <= TID_MAX);

    always_comb begin
        if (op > OP_WRITE_IDLE)             status = ST_BADREQ;
        else if (idx >= DEPTH_I)            status = ST_RANGE;
        else if (ent_busy)                  status = ST_RETRY;
        else if (op_is_wr && !fields_ok)    status = ST_BADREQ;
        else                                status = ST_OK;
    end

    assign is_read  = (op == OP_READ) || (op == OP_READ_CLR);
    assign do_write = (status == ST_OK) &&
                      ((op == OP_WRITE) || ((op == OP_WRITE_IDLE) && !ent_act));
    assign do_clear = (status == ST_OK) && (op == OP_READ_CLR);

endmodule

// File: rtl/nh_quar_timer.sv
module nh_quar_timer #(
    parameter  int DEPTH = 16,
    parameter  int HOLD  = 12,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(HOLD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    start_sel,
    output logic [DEPTH-1:0] busy
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (start && (start_sel == AW'(g)))  cnt_d = CW'(HOLD);
            else if (cnt_q != '0)                cnt_d = cnt_q - 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign busy[g] = (cnt_q != '0);
    end

endmodule

// File: rtl/nh_lookup_port.sv
module nh_lookup_port
    import nh_adj_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic [IDX_W-1:0]      idx,
    input  nh_entry_t [DEPTH-1:0] tbl,
    output logic                  hit_now,
    output logic [AW-1:0]         hit_sel,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic [EGR_W-1:0]      egress,
    output logic [TACT_W-1:0]     tact,
    output logic [TID_W-1:0]      tid,
    output logic [MAC_W-1:0]      mac
);
    localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic [EGR_W-1:0]  egress;
        logic [TACT_W-1:0] tact;
        logic [TID_W-1:0]  tid;
        logic [MAC_W-1:0]  mac;
    } lk_state_t;

    lk_state_t lk_d, lk_q;
    logic      in_rng;
    nh_entry_t ent;

    assign in_rng  = (idx < DEPTH_I);
    assign hit_sel = in_rng ? idx[AW-1:0] : '0;
    assign ent     = tbl[hit_sel];
    assign hit_now = req && in_rng && ent.vld;

    always_comb begin
        lk_d     = '0;
        lk_d.vld = req;
        lk_d.hit = hit_now;
        if (hit_now) begin
            lk_d.egress = ent.egress;
            lk_d.tact   = TACT_W'(ent.tact);
            lk_d.tid    = TID_W'(ent.tid);
            lk_d.mac    = ent.mac;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign rsp_valid = lk_q.vld;
    assign rsp_hit   = lk_q.hit;
    assign egress    = lk_q.egress;
    assign tact      = lk_q.tact;
    assign tid       = lk_q.tid;
    assign mac       = lk_q.mac;

endmodule

// File: rtl/nh_adj_table.sv
module nh_adj_table
    import nh_adj_pkg::*;
#(
    parameter  int DEPTH       = 16,
    parameter  int QUAR_CYCLES = 12,
    localparam int AW          = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [OP_W-1:0]     cmd_op,
    input  logic [IDX_LO_W-1:0] cmd_idx_lo,
    input  logic [IDX_HI_W-1:0] cmd_idx_hi,
    input  logic                cmd_wr_valid,
    input  logic [EGR_W-1:0]    cmd_wr_egress,
    input  logic [TACT_W-1:0]   cmd_wr_trap_act,
    input  logic [TID_W-1:0]    cmd_wr_trap_id,
    input  logic [MAC_W-1:0]    cmd_wr_mac,
    output logic                rsp_valid,
    output logic [ST_W-1:0]     rsp_status,
    output logic                rsp_entry_valid,
    output logic                rsp_entry_active,
    output logic [EGR_W-1:0]    rsp_egress,
    output logic [TACT_W-1:0]   rsp_trap_act,
    output logic [TID_W-1:0]    rsp_trap_id,
    output logic [MAC_W-1:0]    rsp_mac,
    input  logic                lk_req,
    input  logic [IDX_W-1:0]    lk_idx,
    output logic                lk_rsp_valid,
    output logic                lk_hit,
    output logic [EGR_W-1:0]    lk_egress,
    output logic [TACT_W-1:0]   lk_trap_act,
    output logic [TID_W-1:0]    lk_trap_id,
    output logic [MAC_W-1:0]    lk_mac
);
    localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);

    typedef struct packed {
        logic                  s1_vld;
        logic [OP_W-1:0]       s1_op;
        logic [IDX_W-1:0]      s1_idx;
        logic                  s1_wv;
        logic [EGR_W-1:0]      s1_egr;
        logic [TACT_W-1:0]     s1_tact;
        logic [TID_W-1:0]      s1_tid;
        logic [MAC_W-1:0]      s1_mac;
        logic                  rsp_vld;
        logic [ST_W-1:0]       rsp_st;
        nh_entry_t             rsp_e;
        nh_entry_t [DEPTH-1:0] tbl;
    } state_t;

    state_t           st_d, st_q;
    logic             accept;
    logic [AW-1:0]    sel;
    nh_entry_t        wr_e;
    logic [ST_W-1:0]  status;
    logic             is_read, do_write, do_clear;
    logic [DEPTH-1:0] busy;
    logic             qstart;
    logic             lk_hit_now;
    logic [AW-1:0]    lk_sel;

    assign accept    = cmd_valid && !st_q.s1_vld;
    assign cmd_ready = !st_q.s1_vld;
    assign sel       = (st_q.s1_idx < DEPTH_I) ? st_q.s1_idx[AW-1:0] : '0;
    assign qstart    = st_q.s1_vld && do_write && !st_q.s1_wv;

    always_comb begin
        wr_e        = '0;
        wr_e.vld    = st_q.s1_wv;
        wr_e.act    = st_q.s1_wv;
        wr_e.egress = st_q.s1_egr;
        wr_e.tact   = st_q.s1_tact[TACT_ST_W-1:0];
        wr_e.tid    = st_q.s1_tid[0];
        wr_e.mac    = st_q.s1_mac;
    end

    nh_cmd_decode #(.DEPTH(DEPTH)) i_dec (
        .op       (st_q.s1_op),
        .idx      (st_q.s1_idx),
        .wr_tact  (st_q.s1_tact),
        .wr_tid   (st_q.s1_tid),
        .ent_busy (busy[sel]),
        .ent_act  (st_q.tbl[sel].act),
        .status   (status),
        .is_read  (is_read),
        .do_write (do_write),
        .do_clear (do_clear)
    );

    nh_quar_timer #(.DEPTH(DEPTH), .HOLD(QUAR_CYCLES)) i_quar (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (qstart),
        .start_sel (sel),
        .busy      (busy)
    );

    nh_lookup_port #(.DEPTH(DEPTH)) i_lk (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (lk_req),
        .idx       (lk_idx),
        .tbl       (st_q.tbl),
        .hit_now   (lk_hit_now),
        .hit_sel   (lk_sel),
        .rsp_valid (lk_rsp_valid),
        .rsp_hit   (lk_hit),
        .egress    (lk_egress),
        .tact      (lk_trap_act),
        .tid       (lk_trap_id),
        .mac       (lk_mac)
    );

    always_comb begin
        st_d         = st_q;
        st_d.s1_vld  = accept;
        st_d.rsp_vld = st_q.s1_vld;
        if (accept) begin
            st_d.s1_op   = cmd_op;
            st_d.s1_idx  = {cmd_idx_hi, cmd_idx_lo};
            st_d.s1_wv   = cmd_wr_valid;
            st_d.s1_egr  = cmd_wr_egress;
            st_d.s1_tact = cmd_wr_trap_act;
            st_d.s1_tid  = cmd_wr_trap_id;
            st_d.s1_mac  = cmd_wr_mac;
        end
        if (st_q.s1_vld) begin
            st_d.rsp_st = status;
            st_d.rsp_e  = '0;
            if (status == ST_OK)
                st_d.rsp_e = (is_read || !do_write) ? st_q.tbl[sel] : wr_e;
            if (do_write) st_d.tbl[sel]     = wr_e;
            if (do_clear) st_d.tbl[sel].act = 1'b0;
        end
        // management effect first, lookup hit afterwards so it is never lost
        if (lk_hit_now) st_d.tbl[lk_sel].act = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid        = st_q.rsp_vld;
    assign rsp_status       = st_q.rsp_st;
    assign rsp_entry_valid  = st_q.rsp_e.vld;
    assign rsp_entry_active = st_q.rsp_e.act;
    assign rsp_egress       = st_q.rsp_e.egress;
    assign rsp_trap_act     = TACT_W'(st_q.rsp_e.tact);
    assign rsp_trap_id      = TID_W'(st_q.rsp_e.tid);
    assign rsp_mac          = st_q.rsp_e.mac;

endmodule

// File: rtl/nh_adj_table_chk.sv
module nh_adj_table_chk
    import nh_adj_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic                cmd_ready,
    input logic [OP_W-1:0]     cmd_op,
    input logic [IDX_LO_W-1:0] cmd_idx_lo,
    input logic [IDX_HI_W-1:0] cmd_idx_hi,
    input logic                rsp_valid,
    input logic [ST_W-1:0]     rsp_status,
    input logic                rsp_entry_valid,
    input logic                rsp_entry_active,
    input logic [TACT_W-1:0]   rsp_trap_act,
    input logic [MAC_W-1:0]    rsp_mac,
    input logic                lk_req,
    input logic                lk_rsp_valid,
    input logic                lk_hit,
    input logic [EGR_W-1:0]    lk_egress,
    input logic [MAC_W-1:0]    lk_mac
);
    localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);

    logic acc;
    logic acc_far;
    assign acc     = cmd_valid && cmd_ready;
    assign acc_far = acc && (cmd_op <= OP_WRITE_IDLE) && ({cmd_idx_hi, cmd_idx_lo} >= DEPTH_I);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!rsp_valid && !lk_rsp_valid)); // R1

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc, 2)); // R11

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !cmd_ready); // R11

    AST_LK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_rsp_valid); // R9

    AST_LK_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_rsp_valid && !lk_hit) |-> (lk_egress == '0 && lk_mac == '0)); // R9

    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != ST_OK) |-> (!rsp_entry_valid && rsp_mac == '0)); // R6

    AST_FAR_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(acc_far, 2)) |-> (rsp_status == ST_RANGE)); // R7

    AST_TRAP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == ST_OK) |-> (rsp_trap_act <= TACT_MAX)); // R8

    AST_WRITE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == ST_OK && $past(acc && cmd_op == OP_WRITE, 2))
        |-> (rsp_entry_active == rsp_entry_valid)); // R4

endmodule

bind nh_adj_table nh_adj_table_chk #(.DEPTH(DEPTH)) i_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cmd_valid        (cmd_valid),
    .cmd_ready        (cmd_ready),
    .cmd_op           (cmd_op),
    .cmd_idx_lo       (cmd_idx_lo),
    .cmd_idx_hi       (cmd_idx_hi),
    .rsp_valid        (rsp_valid),
    .rsp_status       (rsp_status),
    .rsp_entry_valid  (rsp_entry_valid),
    .rsp_entry_active (rsp_entry_active),
    .rsp_trap_act     (rsp_trap_act),
    .rsp_mac          (rsp_mac),
    .lk_req           (lk_req),
    .lk_rsp_valid     (lk_rsp_valid),
    .lk_hit           (lk_hit),
    .lk_egress        (lk_egress),
    .lk_mac           (lk_mac)
);

// File: tb/test_nh_adj_table.sv
module test_nh_adj_table;
    import nh_adj_pkg::*;

    localparam int D = 16;
    localparam int Q = 12;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [3:0]    cmd_op = '0;
    logic [15:0]   cmd_idx_lo = '0;
    logic [7:0]    cmd_idx_hi = '0;
    logic          cmd_wr_valid = 1'b0;
    logic [15:0]   cmd_wr_egress = '0;
    logic [3:0]    cmd_wr_trap_act = '0;
    logic [7:0]    cmd_wr_trap_id = '0;
    logic [47:0]   cmd_wr_mac = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_status;
    logic          rsp_entry_valid, rsp_entry_active;
    logic [15:0]   rsp_egress;
    logic [3:0]    rsp_trap_act;
    logic [7:0]    rsp_trap_id;
    logic [47:0]   rsp_mac;
    logic          lk_req = 1'b0;
    logic [23:0]   lk_idx = '0;
    logic          lk_rsp_valid, lk_hit;
    logic [15:0]   lk_egress;
    logic [3:0]    lk_trap_act;
    logic [7:0]    lk_trap_id;
    logic [47:0]   lk_mac;

    nh_adj_table #(.DEPTH(D), .QUAR_CYCLES(Q)) i_nh_adj_table (.*);

    // reference model state
    logic        m_v [D];
    logic        m_a [D];
    logic [15:0] m_eg [D];
    logic [3:0]  m_ta [D];
    logic [7:0]  m_ti [D];
    logic [47:0] m_mac [D];
    int          m_q [D];
    logic        pend;
    int          p_op, p_idx;
    logic        p_wv;
    logic [15:0] p_eg;
    logic [3:0]  p_ta;
    logic [7:0]  p_ti;
    logic [47:0] p_mac;
    // expected outputs
    logic        e_rdy, e_rv, e_v, e_a, e_lv, e_lh;
    int          e_st;
    logic [15:0] e_eg, e_leg;
    logic [3:0]  e_ta, e_lta;
    logic [7:0]  e_ti, e_lti;
    logic [47:0] e_mac, e_lmac;
    string       e_tag, l_tag;
    // model scratch
    int          li, si, qs;
    logic        hit;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) begin
                m_v[i] = 0; m_a[i] = 0; m_eg[i] = '0; m_ta[i] = '0;
                m_ti[i] = '0; m_mac[i] = '0; m_q[i] = 0;
            end
            pend = 0; e_rdy = 1; e_rv = 0; e_lv = 0; e_lh = 0;
        end else begin
            li = int'(lk_idx);
            hit = lk_req && (li < D) && m_v[li];
            e_lv = lk_req; e_lh = hit; l_tag = "R9";
            e_leg = hit ? m_eg[li] : '0;
            e_lta = hit ? m_ta[li] : '0;
            e_lti = hit ? m_ti[li] : '0;
            e_lmac = hit ? m_mac[li] : '0;
            qs = -1;
            e_rv = pend;
            if (pend) begin
                e_v = 0; e_a = 0; e_eg = '0; e_ta = '0; e_ti = '0; e_mac = '0;
                if (p_op > 3) begin e_st = 3; e_tag = "R8"; end
                else if (p_idx >= D) begin e_st = 2; e_tag = "R7"; end
                else if (m_q[p_idx] > 0) begin e_st = 1; e_tag = "R6"; end
                else if ((p_op == 1 || p_op == 3) && (p_ta > 4 || p_ti > 1)) begin e_st = 3; e_tag = "R8"; end
                else begin
                    e_st = 0; si = p_idx;
                    if (p_op == 1 || (p_op == 3 && !m_a[si])) begin
                        m_v[si] = p_wv; m_a[si] = p_wv; m_eg[si] = p_eg;
                        m_ta[si] = p_ta; m_ti[si] = p_ti; m_mac[si] = p_mac;
                        if (!p_wv) qs = si;
                    end
                    e_v = m_v[si]; e_a = m_a[si]; e_eg = m_eg[si];
                    e_ta = m_ta[si]; e_ti = m_ti[si]; e_mac = m_mac[si];
                    if (p_op == 0) e_tag = "R2";
                    else if (p_op == 1) e_tag = "R4";
                    else if (p_op == 3) e_tag = "R5";
                    else begin
                        m_a[si] = 0;
                        if (hit && li == si) begin e_tag = "R10"; l_tag = "R10"; end
                        else e_tag = "R3";
                    end
                end
            end
            for (int i = 0; i < D; i++) if (m_q[i] > 0) m_q[i]--;
            if (qs >= 0) m_q[qs] = Q;
            if (hit) m_a[li] = 1;
            if (pend) pend = 0;
            else if (cmd_valid) begin
                pend = 1; p_op = int'(cmd_op); p_idx = int'({cmd_idx_hi, cmd_idx_lo});
                p_wv = cmd_wr_valid; p_eg = cmd_wr_egress; p_ta = cmd_wr_trap_act;
                p_ti = cmd_wr_trap_id; p_mac = cmd_wr_mac;
            end
            e_rdy = !pend;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R11", "cmd_ready", 64'(cmd_ready), 64'(e_rdy));
            chk("R11", "rsp_valid", 64'(rsp_valid), 64'(e_rv));
            if (e_rv) begin
                chk(e_tag, "status", 64'(rsp_status), 64'(e_st));
                chk(e_tag, "entry_valid", 64'(rsp_entry_valid), 64'(e_v));
                chk(e_tag, "entry_active", 64'(rsp_entry_active), 64'(e_a));
                chk(e_tag, "egress", 64'(rsp_egress), 64'(e_eg));
                chk(e_tag, "trap_act", 64'(rsp_trap_act), 64'(e_ta));
                chk(e_tag, "trap_id", 64'(rsp_trap_id), 64'(e_ti));
                chk(e_tag, "mac", 64'(rsp_mac), 64'(e_mac));
            end
            chk(l_tag, "lk_rsp_valid", 64'(lk_rsp_valid), 64'(e_lv));
            if (e_lv) begin
                chk(l_tag, "lk_hit", 64'(lk_hit), 64'(e_lh));
                chk(l_tag, "lk_egress", 64'(lk_egress), 64'(e_leg));
                chk(l_tag, "lk_trap_act", 64'(lk_trap_act), 64'(e_lta));
                chk(l_tag, "lk_trap_id", 64'(lk_trap_id), 64'(e_lti));
                chk(l_tag, "lk_mac", 64'(lk_mac), 64'(e_lmac));
            end
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic cmd(input logic [3:0] op, input logic [23:0] idx, input logic wv,
                       input logic [15:0] eg, input logic [3:0] ta, input logic [7:0] ti,
                       input logic [47:0] mac, input logic with_lk);
        while (!cmd_ready) step();
        cmd_valid = 1; cmd_op = op; {cmd_idx_hi, cmd_idx_lo} = idx;
        cmd_wr_valid = wv; cmd_wr_egress = eg; cmd_wr_trap_act = ta;
        cmd_wr_trap_id = ti; cmd_wr_mac = mac;
        step();
        cmd_valid = 0;
        if (with_lk) begin lk_req = 1; lk_idx = idx; end
        step();
        lk_req = 0;
    endtask

    task automatic look(input logic [23:0] idx);
        lk_req = 1; lk_idx = idx;
        step();
        lk_req = 0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R1: quiet outputs right after reset
        chk("R1", "cmd_ready", 64'(cmd_ready), 64'd1);
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1", "lk_rsp_valid", 64'(lk_rsp_valid), 64'd0);
        cmd(4'd0, 24'd2, 0, 0, 0, 0, 0, 0);                              // R1 read of reset entry
        look(24'd3);                                                     // R9 miss
        cmd(4'd1, 24'd3, 1, 16'h0042, 4'd2, 8'd1, 48'h0a0b0c0d0e0f, 0); // R4
        cmd(4'd0, 24'd3, 0, 0, 0, 0, 0, 0);                              // R2
        look(24'd3);                                                     // R9 hit
        cmd(4'd2, 24'd3, 0, 0, 0, 0, 0, 0);                              // R3
        cmd(4'd0, 24'd3, 0, 0, 0, 0, 0, 0);                              // R3 flag cleared
        cmd(4'd3, 24'd3, 1, 16'h0077, 4'd4, 8'd0, 48'h111111111111, 0); // R5 applies
        cmd(4'd2, 24'd3, 0, 0, 0, 0, 0, 0);
        look(24'd3);                                                     // sets activity
        cmd(4'd3, 24'd3, 1, 16'h0099, 4'd1, 8'd1, 48'h222222222222, 0); // R5 dropped
        cmd(4'd0, 24'd3, 0, 0, 0, 0, 0, 0);
        cmd(4'd2, 24'd3, 0, 0, 0, 0, 0, 1);                              // R10 collision
        cmd(4'd0, 24'd3, 0, 0, 0, 0, 0, 0);
        cmd(4'd1, 24'd5, 1, 16'h0005, 4'd0, 8'd0, 48'h555555555555, 0);
        cmd(4'd1, 24'd5, 0, 0, 0, 0, 0, 0);                              // R6 start quarantine
        cmd(4'd0, 24'd5, 0, 0, 0, 0, 0, 0);                              // R6 retry
        cmd(4'd1, 24'd5, 1, 16'h0006, 4'd0, 8'd0, 48'h666666666666, 0); // R6 retry
        repeat (Q) step();
        cmd(4'd0, 24'd5, 0, 0, 0, 0, 0, 0);                              // R6 window over
        cmd(4'd0, 24'd16, 0, 0, 0, 0, 0, 0);                             // R7 at depth
        cmd(4'd1, 24'h010003, 1, 16'h0001, 4'd0, 8'd0, 48'h1, 0);       // R7 high part
        cmd(4'd7, 24'd3, 0, 0, 0, 0, 0, 0);                              // R8 bad code
        cmd(4'd1, 24'd4, 1, 16'h0001, 4'd5, 8'd0, 48'h1, 0);            // R8 bad action
        cmd(4'd3, 24'd4, 1, 16'h0001, 4'd0, 8'd2, 48'h1, 0);            // R8 bad id
        cmd(4'd0, 24'd4, 0, 0, 0, 0, 0, 0);
        look(24'd17);                                                    // R9 out of range
        for (int n = 0; n < 6000; n++) begin
            lk_req = 1'($urandom % 2);
            lk_idx = 24'(10 + ($urandom % 8));
            if (cmd_ready && ($urandom % 3 != 0)) begin
                cmd_valid = 1;
                cmd_op = ($urandom % 10 == 0) ? 4'(4 + $urandom % 12) : 4'($urandom % 4);
                cmd_idx_hi = ($urandom % 16 == 0) ? 8'd1 : 8'd0;
                cmd_idx_lo = 16'(10 + ($urandom % 8));
                cmd_wr_valid = 1'($urandom % 4 != 0);
                cmd_wr_egress = 16'($urandom);
                cmd_wr_trap_act = 4'($urandom % 6);
                cmd_wr_trap_id = ($urandom % 8 == 0) ? 8'd2 : 8'($urandom % 2);
                cmd_wr_mac = {16'($urandom), 32'($urandom)};
            end else begin
                cmd_valid = 0;
            end
            step();
        end
        cmd_valid = 0; lk_req = 0;
        repeat (4) step();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL R11 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule